// File: doc/BRIEF.md
# Narrow-to-Word DMA Packer with Write-One Flush

This block sits between a narrow peripheral data bus and a 32-bit DMA word path, one lane per channel. When a channel moves data from the device toward memory (read direction), narrow transfers of 8, 16 or 32 bits are gathered into a word register, filling byte lanes from lane 0 upward. A finished word leaves on the word port with a byte-enable mask. When a channel moves data toward the device (write direction), a word taken from the word port is cut into narrow pieces, lowest lanes first. All transfers use valid/ready handshakes.

Each channel has a flush bit that software sets by writing one. Writing zero does nothing. In the read direction the flush pushes out a partly filled word, and its byte-enable mask marks only the lanes that were filled. In the write direction the flush throws away the pieces still waiting in the word register. When the operation is done, the hardware clears the bit again. A flush that finds the register empty completes in the cycle after it is set.

Each channel runs a three-state machine. FILL gathers narrow data, or waits for a word. EMIT offers a packed word. SPLIT hands out narrow pieces. The named transitions are:
- FILL→EMIT (word complete, or flush with a partial word)
- EMIT→FILL (word handshake)
- FILL→SPLIT (word loaded)
- SPLIT→FILL (last piece taken, or flush discard)
- FILL→FILL (flush on an empty register)

Top module: `dma_pack_unit`

## Requirements
- R1: After reset every flush bit reads 0, no word or narrow output is valid, and a read-direction channel is ready for narrow input.
- R2: At width code 00 (8 bits), four narrow transfers fill lanes 0,1,2,3 in that order. Only bits [7:0] of the narrow input are used. The word is then offered with byte enables 4'b1111, with no flush needed.
- R3: At width code 01 (16 bits), two transfers fill lanes 1:0 and then 3:2. Only bits [15:0] of the narrow input are used.
- R4: At width code 10 (32 bits), each single narrow transfer produces a complete word.
- R5: Writing a 1 to bit i of the flush control sets the flush status bit of channel i. Writing a 0 leaves that bit unchanged.
- R6: A read-direction flush with k filled bytes (0<k<4) offers the partial word with byte enables (1<<k)-1. The flush bit clears in the cycle after that word's handshake.
- R7: A flush on a channel whose register is empty clears its bit in the next cycle and offers no word.
- R8: In the write direction, a loaded word is handed out as narrow pieces from lane 0 upward, each piece the width of the current setting and zero-extended. After the last piece the channel is ready for a new word.
- R9: A write-direction flush discards the pieces that remain. The flush bit clears one cycle later, and the next narrow output comes from the next loaded word.
- R10: While a channel's flush bit is set, that channel does not accept narrow input, offer narrow output, or accept a new word.
- R11: Flush bits 0, 1 and 2 act only on channels 0, 1 and 2 respectively.
- R12: An offered word, together with its byte enables, stays valid and unchanged until it is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_wr | input | 1 | Write strobe for the flush control |
| flush_wdata | input | NCH | Write-one flush request, bit i for channel i |
| flush_busy | output | NCH | Flush status per channel, cleared by hardware |
| ch_dir_rd | input | NCH | 1 = device-to-word (pack), 0 = word-to-device (unpack) |
| ch_width | input | 2*NCH | Device width code per channel: 00=8, 01=16, 10=32 |
| dev_in_valid | input | NCH | Narrow input valid |
| dev_in_data | input | 32*NCH | Narrow input data, low bits used |
| dev_in_ready | output | NCH | Narrow input accepted |
| dev_out_valid | output | NCH | Narrow output valid |
| dev_out_data | output | 32*NCH | Narrow output data, zero-extended |
| dev_out_ready | input | NCH | Narrow output taken |
| wd_out_valid | output | NCH | Packed word valid |
| wd_out_data | output | 32*NCH | Packed word |
| wd_out_be | output | 4*NCH | Byte enables of the packed word |
| wd_out_ready | input | NCH | Packed word taken |
| wd_in_valid | input | NCH | Word to unpack valid |
| wd_in_data | input | 32*NCH | Word to unpack |
| wd_in_ready | output | NCH | Word to unpack accepted |

## Verification
A flush write can land in the same clock edge as a narrow transfer, because the input is still ready until the flush bit is registered. The bench provokes this in two ways. First, it writes the flush together with the fourth byte of a word, and expects a full word with enables 1111, after which the flush bit clears on that word's handshake. Second, it writes the flush together with the first byte into an empty register, and expects a one-lane word with enables 0001 one cycle later, not an immediate empty-flush completion.

// File: rtl/dma_pack_pkg.sv
package dma_pack_pkg;

    typedef enum logic [1:0] {
        DW_8  = 2'b00,
        DW_16 = 2'b01,
        DW_32 = 2'b10
    } dev_width_e;

    typedef enum logic [1:0] {
        ST_FILL  = 2'b00,
        ST_EMIT  = 2'b01,
        ST_SPLIT = 2'b10
    } pk_state_e;

endpackage

// File: rtl/pack_lanes.sv
module pack_lanes
    import dma_pack_pkg::*;
#(
    parameter int WORD_W = 32,
    localparam int BYTES = WORD_W / 8,
    localparam int CNT_W = $clog2(BYTES) + 1
) (
    input  logic [1:0]        width,
    input  logic [CNT_W-1:0]  pos,
    input  logic [WORD_W-1:0] word_q,
    input  logic [WORD_W-1:0] nar_in,
    output logic [WORD_W-1:0] merged,
    output logic [WORD_W-1:0] piece,
    output logic [CNT_W-1:0]  step,
    output logic [BYTES-1:0]  be_mask
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BYTES);

    logic [WORD_W-1:0] nar_mask;
    logic [CNT_W+2:0]  bit_ofs;

    always_comb begin
        unique case (dev_width_e'(width))
            DW_8:    step = CNT_W'(1);
            DW_16:   step = (BYTES >= 2) ? CNT_W'(2) : FULL_CNT;
            default: step = FULL_CNT;
        endcase
    end

    for (genvar b = 0; b < BYTES; b++) begin : g_lane
        assign nar_mask[b*8 +: 8] = (CNT_W'(b) < step) ? 8'hFF : 8'h00;
        assign be_mask[b]         = (CNT_W'(b) < pos);
    end

    assign bit_ofs = {pos, 3'b000};
    assign merged  = word_q | ((nar_in & nar_mask) << bit_ofs);
    assign piece   = (word_q >> bit_ofs) & nar_mask;

endmodule

// File: rtl/pack_chan.sv
module pack_chan
    import dma_pack_pkg::*;
#(
    parameter int WORD_W = 32,
    localparam int BYTES = WORD_W / 8,
    localparam int CNT_W = $clog2(BYTES) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dir_rd,
    input  logic [1:0]        width,
    input  logic              flush_set,
    output logic              flush_busy,
    input  logic              dev_in_valid,
    input  logic [WORD_W-1:0] dev_in_data,
    output logic              dev_in_ready,
    output logic              dev_out_valid,
    output logic [WORD_W-1:0] dev_out_data,
    input  logic              dev_out_ready,
    output logic              wd_out_valid,
    output logic [WORD_W-1:0] wd_out_data,
    output logic [BYTES-1:0]  wd_out_be,
    input  logic              wd_out_ready,
    input  logic              wd_in_valid,
    input  logic [WORD_W-1:0] wd_in_data,
    output logic              wd_in_ready
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BYTES);

    pk_state_e         st, st_n;
    logic [CNT_W-1:0]  cnt, cnt_n, cnt_sum, step;
    logic [WORD_W-1:0] wreg, wreg_n, merged, piece;
    logic [BYTES-1:0]  be_mask;
    logic              flush_q, flush_done;

    pack_lanes #(.WORD_W(WORD_W)) u_lanes (
        .width   (width),
        .pos     (cnt),
        .word_q  (wreg),
        .nar_in  (dev_in_data),
        .merged  (merged),
        .piece   (piece),
        .step    (step),
        .be_mask (be_mask)
    );

    assign cnt_sum = cnt + step;

    // next-state logic
    always_comb begin
        st_n       = st;
        cnt_n      = cnt;
        wreg_n     = wreg;
        flush_done = 1'b0;
        unique case (st)
            ST_FILL: begin
                if (flush_q) begin
                    if (dir_rd && cnt != '0) begin
                        st_n = ST_EMIT;
                    end else begin
                        flush_done = 1'b1;
                        cnt_n      = '0;
                        wreg_n     = '0;
                    end
                end else if (dir_rd) begin
                    if (dev_in_valid) begin
                        wreg_n = merged;
                        cnt_n  = cnt_sum;
                        if (cnt_sum >= FULL_CNT) st_n = ST_EMIT;
                    end
                end else if (wd_in_valid) begin
                    wreg_n = wd_in_data;
                    cnt_n  = '0;
                    st_n   = ST_SPLIT;
                end
            end
            ST_EMIT: begin
                if (wd_out_ready) begin
                    st_n       = ST_FILL;
                    cnt_n      = '0;
                    wreg_n     = '0;
                    flush_done = flush_q;
                end
            end
            ST_SPLIT: begin
                if (flush_q) begin
                    st_n       = ST_FILL;
                    cnt_n      = '0;
                    wreg_n     = '0;
                    flush_done = 1'b1;
                end else if (dev_out_ready) begin
                    cnt_n = cnt_sum;
                    if (cnt_sum >= FULL_CNT) begin
                        st_n   = ST_FILL;
                        cnt_n  = '0;
                        wreg_n = '0;
                    end
                end
            end
            default: begin
                st_n   = ST_FILL;
                cnt_n  = '0;
                wreg_n = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_FILL;
            cnt     <= '0;
            wreg    <= '0;
            flush_q <= 1'b0;
        end else begin
            st      <= st_n;
            cnt     <= cnt_n;
            wreg    <= wreg_n;
            flush_q <= flush_set | (flush_q & ~flush_done);
        end
    end

    // outputs
    always_comb begin
        dev_in_ready  = (st == ST_FILL) && dir_rd && !flush_q;
        wd_in_ready   = (st == ST_FILL) && !dir_rd && !flush_q;
        dev_out_valid = (st == ST_SPLIT) && !flush_q;
        dev_out_data  = (st == ST_SPLIT) ? piece : '0;
        wd_out_valid  = (st == ST_EMIT);
        wd_out_data   = wreg;
        wd_out_be     = be_mask;
        flush_busy    = flush_q;
    end

    AST_EMPTY_FLUSH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        flush_busy && st == ST_FILL && (cnt == '0 || !dir_rd) && !flush_set |=> !flush_busy); // R7
    AST_FLUSH_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        flush_busy |-> !dev_in_ready && !dev_out_valid && !wd_in_ready); // R10
    AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        wd_out_valid && !wd_out_ready |=> wd_out_valid && $stable(wd_out_data) && $stable(wd_out_be)); // R12
    AST_FULL_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
        wd_out_valid && !flush_busy |-> wd_out_be == {BYTES{1'b1}}); // R2
    AST_LOW_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        wd_out_valid |-> wd_out_be != '0 && ((wd_out_be & (wd_out_be + 1'b1)) == '0)); // R6

endmodule

// File: rtl/dma_pack_unit.sv
module dma_pack_unit #(
    parameter int NCH    = 3,
    parameter int WORD_W = 32,
    localparam int BYTES = WORD_W / 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  flush_wr,
    input  logic [NCH-1:0]        flush_wdata,
    output logic [NCH-1:0]        flush_busy,
    input  logic [NCH-1:0]        ch_dir_rd,
    input  logic [2*NCH-1:0]      ch_width,
    input  logic [NCH-1:0]        dev_in_valid,
    input  logic [WORD_W*NCH-1:0] dev_in_data,
    output logic [NCH-1:0]        dev_in_ready,
    output logic [NCH-1:0]        dev_out_valid,
    output logic [WORD_W*NCH-1:0] dev_out_data,
    input  logic [NCH-1:0]        dev_out_ready,
    output logic [NCH-1:0]        wd_out_valid,
    output logic [WORD_W*NCH-1:0] wd_out_data,
    output logic [BYTES*NCH-1:0]  wd_out_be,
    input  logic [NCH-1:0]        wd_out_ready,
    input  logic [NCH-1:0]        wd_in_valid,
    input  logic [WORD_W*NCH-1:0] wd_in_data,
    output logic [NCH-1:0]        wd_in_ready
);

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        pack_chan #(.WORD_W(WORD_W)) u_chan (
            .clk           (clk),
            .rst_n         (rst_n),
            .dir_rd        (ch_dir_rd[c]),
            .width         (ch_width[2*c +: 2]),
            .flush_set     (flush_wr & flush_wdata[c]),
            .flush_busy    (flush_busy[c]),
            .dev_in_valid  (dev_in_valid[c]),
            .dev_in_data   (dev_in_data[WORD_W*c +: WORD_W]),
            .dev_in_ready  (dev_in_ready[c]),
            .dev_out_valid (dev_out_valid[c]),
            .dev_out_data  (dev_out_data[WORD_W*c +: WORD_W]),
            .dev_out_ready (dev_out_ready[c]),
            .wd_out_valid  (wd_out_valid[c]),
            .wd_out_data   (wd_out_data[WORD_W*c +: WORD_W]),
            .wd_out_be     (wd_out_be[BYTES*c +: BYTES]),
            .wd_out_ready  (wd_out_ready[c]),
            .wd_in_valid   (wd_in_valid[c]),
            .wd_in_data    (wd_in_data[WORD_W*c +: WORD_W]),
            .wd_in_ready   (wd_in_ready[c])
        );
    end

endmodule

// File: tb/tb_dma_pack_unit.sv
`timescale 1ns/1ps
module tb_dma_pack_unit;
    localparam int NCH = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flush_wr = 1'b0;
    logic [NCH-1:0] flush_wdata = '0;
    logic [NCH-1:0] flush_busy;
    logic [NCH-1:0] ch_dir_rd = 3'b001;
    logic [2*NCH-1:0] ch_width = '0;
    logic [NCH-1:0] dev_in_valid = '0;
    logic [32*NCH-1:0] dev_in_data = '0;
    logic [NCH-1:0] dev_in_ready;
    logic [NCH-1:0] dev_out_valid;
    logic [32*NCH-1:0] dev_out_data;
    logic [NCH-1:0] dev_out_ready = '0;
    logic [NCH-1:0] wd_out_valid;
    logic [32*NCH-1:0] wd_out_data;
    logic [4*NCH-1:0] wd_out_be;
    logic [NCH-1:0] wd_out_ready = '0;
    logic [NCH-1:0] wd_in_valid = '0;
    logic [32*NCH-1:0] wd_in_data = '0;
    logic [NCH-1:0] wd_in_ready;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    dma_pack_unit #(.NCH(NCH), .WORD_W(32)) dut (.*);

    always #2.5 clk = ~clk;

    localparam int NV = 4;
    localparam logic [1:0]  VW [NV] = '{2'b00, 2'b00, 2'b01, 2'b10};
    localparam logic [31:0] VS [NV] = '{32'h4433_2211, 32'h8899_AABB, 32'hBEEF_CAFE, 32'h1234_5678};
    localparam logic [31:0] VE [NV] = '{32'h4433_2211, 32'h8899_AABB, 32'hBEEF_CAFE, 32'h1234_5678};

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push_byte(logic [31:0] d);
        dev_in_valid[0] = 1'b1;
        dev_in_data[31:0] = d;
        tick();
        dev_in_valid[0] = 1'b0;
    endtask

    task automatic pop_word();
        wd_out_ready[0] = 1'b1;
        tick();
        wd_out_ready[0] = 1'b0;
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk("R1 busy", 32'(flush_busy), 32'h0);
        chk("R1 wvalid", 32'(wd_out_valid), 32'h0);
        chk("R1 dvalid", 32'(dev_out_valid), 32'h0);
        chk("R1 in_ready", 32'(dev_in_ready[0]), 32'h1);

        // R2 R3 R4 R12: table-driven packing
        for (int v = 0; v < NV; v++) begin
            int n;
            int sb;
            logic [31:0] m;
            ch_width[1:0] = VW[v];
            n  = 4 >> VW[v];
            sb = 4 / n;
            m  = (sb == 4) ? 32'hFFFF_FFFF : ((32'h1 << (sb*8)) - 1);
            for (int k = 0; k < n; k++)
                push_byte(((VS[v] >> (k*sb*8)) & m) | (32'hA5A5_A5A5 & ~m));
            chk($sformatf("R2/R3/R4 v%0d valid", v), 32'(wd_out_valid[0]), 32'h1);
            chk($sformatf("R2/R3/R4 v%0d data", v), wd_out_data[31:0], VE[v]);
            chk($sformatf("R2 v%0d be", v), 32'(wd_out_be[3:0]), 32'hF);
            tick();
            tick();
            chk($sformatf("R12 v%0d held", v), wd_out_data[31:0], VE[v]);
            chk($sformatf("R12 v%0d held valid", v), 32'(wd_out_valid[0]), 32'h1);
            pop_word();
            chk($sformatf("R2 v%0d taken", v), 32'(wd_out_valid[0]), 32'h0);
        end

        // R6 partial flush, R5 write-zero no effect, R10 block
        ch_width[1:0] = 2'b00;
        push_byte(32'h11);
        push_byte(32'h22);
        flush_wr = 1'b1; flush_wdata = 3'b001;
        tick();
        flush_wr = 1'b0; flush_wdata = '0;
        chk("R5 set", 32'(flush_busy), 32'h1);
        chk("R10 in blocked", 32'(dev_in_ready[0]), 32'h0);
        tick();
        chk("R6 valid", 32'(wd_out_valid[0]), 32'h1);
        chk("R6 data", wd_out_data[31:0], 32'h0000_2211);
        chk("R6 be", 32'(wd_out_be[3:0]), 32'h3);
        flush_wr = 1'b1; flush_wdata = 3'b000;
        tick();
        flush_wr = 1'b0;
        chk("R5 zero no effect", 32'(flush_busy[0]), 32'h1);
        pop_word();
        chk("R6 cleared", 32'(flush_busy[0]), 32'h0);
        chk("R6 word gone", 32'(wd_out_valid[0]), 32'h0);

        // R7 empty flush
        flush_wr = 1'b1; flush_wdata = 3'b001;
        tick();
        flush_wr = 1'b0; flush_wdata = '0;
        chk("R7 set", 32'(flush_busy[0]), 32'h1);
        tick();
        chk("R7 cleared", 32'(flush_busy[0]), 32'h0);
        chk("R7 no word", 32'(wd_out_valid[0]), 32'h0);

        // R11 channel independence
        flush_wr = 1'b1; flush_wdata = 3'b010;
        tick();
        flush_wr = 1'b0; flush_wdata = '0;
        chk("R11 only ch1", 32'(flush_busy), 32'h2);
        tick();
        chk("R11 ch1 cleared", 32'(flush_busy), 32'h0);

        // R8 unpack 8-bit
        ch_dir_rd[0] = 1'b0;
        tick();
        chk("R8 word ready", 32'(wd_in_ready[0]), 32'h1);
        wd_in_valid[0] = 1'b1; wd_in_data[31:0] = 32'h4433_2211;
        tick();
        wd_in_valid[0] = 1'b0;
        dev_out_ready[0] = 1'b1;
        for (int k = 0; k < 4; k++) begin
            chk($sformatf("R8 piece%0d valid", k), 32'(dev_out_valid[0]), 32'h1);
            chk($sformatf("R8 piece%0d", k), dev_out_data[31:0], (32'h4433_2211 >> (8*k)) & 32'hFF);
            tick();
        end
        dev_out_ready[0] = 1'b0;
        chk("R8 done", 32'(dev_out_valid[0]), 32'h0);
        chk("R8 ready again", 32'(wd_in_ready[0]), 32'h1);

        // R8 unpack 16-bit
        ch_width[1:0] = 2'b01;
        wd_in_valid[0] = 1'b1; wd_in_data[31:0] = 32'hDDCC_BBAA;
        tick();
        wd_in_valid[0] = 1'b0;
        dev_out_ready[0] = 1'b1;
        chk("R8 half0", dev_out_data[31:0], 32'h0000_BBAA);
        tick();
        chk("R8 half1", dev_out_data[31:0], 32'h0000_DDCC);
        tick();
        dev_out_ready[0] = 1'b0;
        chk("R8 16 done", 32'(wd_in_ready[0]), 32'h1);

        // R9 write flush discards
        ch_width[1:0] = 2'b00;
        wd_in_valid[0] = 1'b1; wd_in_data[31:0] = 32'h8765_4321;
        tick();
        wd_in_valid[0] = 1'b0;
        dev_out_ready[0] = 1'b1;
        chk("R9 first piece", dev_out_data[31:0], 32'h21);
        tick();
        dev_out_ready[0] = 1'b0;
        flush_wr = 1'b1; flush_wdata = 3'b001;
        tick();
        flush_wr = 1'b0; flush_wdata = '0;
        chk("R10 out blocked", 32'(dev_out_valid[0]), 32'h0);
        chk("R9 busy", 32'(flush_busy[0]), 32'h1);
        tick();
        chk("R9 cleared", 32'(flush_busy[0]), 32'h0);
        chk("R9 no leftover", 32'(dev_out_valid[0]), 32'h0);
        chk("R9 word ready", 32'(wd_in_ready[0]), 32'h1);
        wd_in_valid[0] = 1'b1; wd_in_data[31:0] = 32'h0000_00F0;
        tick();
        wd_in_valid[0] = 1'b0;
        chk("R9 next word piece", dev_out_data[31:0], 32'hF0);
        dev_out_ready[0] = 1'b1;
        repeat (4) tick();
        dev_out_ready[0] = 1'b0;

        // coincidence: flush with the final byte (R2 R6)
        ch_dir_rd[0] = 1'b1;
        tick();
        push_byte(32'h01);
        push_byte(32'h02);
        push_byte(32'h03);
        flush_wr = 1'b1; flush_wdata = 3'b001;
        push_byte(32'h04);
        flush_wr = 1'b0; flush_wdata = '0;
        chk("R2 coincide valid", 32'(wd_out_valid[0]), 32'h1);
        chk("R2 coincide be", 32'(wd_out_be[3:0]), 32'hF);
        chk("R2 coincide data", wd_out_data[31:0], 32'h0403_0201);
        pop_word();
        chk("R6 coincide cleared", 32'(flush_busy[0]), 32'h0);

        // coincidence: flush with the first byte (R6)
        flush_wr = 1'b1; flush_wdata = 3'b001;
        push_byte(32'h5A);
        flush_wr = 1'b0; flush_wdata = '0;
        chk("R6 first-byte no word yet", 32'(wd_out_valid[0]), 32'h0);
        tick();
        chk("R6 first-byte valid", 32'(wd_out_valid[0]), 32'h1);
        chk("R6 first-byte be", 32'(wd_out_be[3:0]), 32'h1);
        chk("R6 first-byte data", wd_out_data[31:0], 32'h0000_005A);
        pop_word();
        chk("R6 first-byte cleared", 32'(flush_busy[0]), 32'h0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog (R1-flow) actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule